// File: doc/BRIEF.md
# Gate-Segmented Frame Packer with Trailer Flag

This block sits in a line-scan capture path. A gate level frames one image of unbounded height. The block forwards the gated pixel stream and cuts it into output frames of at most `MAX_LINES` lines. It closes every output frame with one extra trailer line. The trailer is 32 bits wide and is sent as `32/PIX_W` beats. It says whether the frame finishes the gated image (all ones) or whether more frames of the same gate follow (all zeros). A consumer downstream can therefore rebuild the tall image, and it learns where the image ends from an in-band flag. It needs no side channel for this.

Pixels pass through the block without being registered, and both sides use valid/ready handshakes. When a frame reaches `MAX_LINES` lines, the block holds the next pixel until it has decided which trailer to send. If that pixel arrives with the gate still high, more lines belong to the same gate, so the trailer is all zeros. If the gate drops first, the frame was the last one. A gate that closes in the middle of a frame ends that frame at once, with its partial line count.

Top module: `fpk_gate_packer`

## Requirements
- R1: After reset, with the gate low and no input, `out_valid` is low and `in_ready` is high.
- R2: A pixel accepted while the gate is high appears on the output unchanged, with its `in_eol` copied to `out_eol`. `out_trl` and `out_eof` are low on that beat, and `in_ready` follows `out_ready`.
- R3: `out_sof` is high on the first pixel beat of every output frame and low on every other beat.
- R4: An output frame carries at most `MAX_LINES` lines. The next line of the same gate starts a new frame, after the previous frame's trailer.
- R5: Every frame ends with exactly `32/PIX_W` trailer beats that have `out_trl` high. `out_eol` and `out_eof` are both high on the final trailer beat only, and no pixel beat has `out_eof` high.
- R6: When the gate falls in the middle of a frame, that frame ends with its partial line count. Its trailer beats are all ones (0xFFFFFFFF over the trailer line).
- R7: A frame that is followed by further lines of the same gate has trailer beats that are all zeros.
- R8: When a gate holds an exact multiple of `MAX_LINES` lines, the last full frame gets the all-ones trailer, and no empty frame follows it.
- R9: A gate that opens and closes with no lines produces no output.
- R10: Pixels offered while the gate is low are accepted and discarded; they never reach the output.
- R11: Backpressure loses no pixel and no trailer beat. A stalled trailer beat keeps its data and markers until it is taken.
- R12: The gate changes only between lines and never while a line is partly transferred.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| gate | input | 1 | Image gate level; high while the image is being captured |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted |
| in_data | input | PIX_W | Input pixel value |
| in_eol | input | 1 | Last pixel of an input line |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | PIX_W | Output pixel or trailer byte |
| out_eol | output | 1 | Last beat of an output line (pixel line or trailer line) |
| out_sof | output | 1 | First pixel beat of an output frame |
| out_eof | output | 1 | Last beat of an output frame (final trailer beat) |
| out_trl | output | 1 | Beat belongs to the trailer line |

## Verification
The assertions assume that the source never moves the gate while a line is partly sent. They also assume that a trailer beat which has been offered stays offered until it is taken. The stimulus raises and lowers the gate only at the falling clock edge after a line's final pixel has been accepted. It holds the gate low for many cycles between images, so every trailer drains before the next gate opens. Stray pixels are injected only while the gate is low. Three ready patterns, including periodic stalls, cover the backpressure side.

// File: rtl/fpk_pkg.sv
`timescale 1ns/1ps
package fpk_pkg;
    typedef enum logic [1:0] {
        SEG_RUN  = 2'd0,
        SEG_FULL = 2'd1,
        SEG_WAIT = 2'd2
    } seg_state_e;
endpackage

// File: rtl/fpk_trailer_gen.sv
`timescale 1ns/1ps
module fpk_trailer_gen #(
    parameter int PIX_W     = 8,
    parameter int TRL_BEATS = 32 / PIX_W,
    parameter int BW        = (TRL_BEATS > 1) ? $clog2(TRL_BEATS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_last,
    input  logic             out_ready,
    output logic             active,
    output logic [PIX_W-1:0] data,
    output logic             final_beat,
    output logic             done
);
    typedef struct packed {
        logic          active;
        logic          last;
        logic [BW-1:0] beat;
    } trl_t;

    trl_t trl_d, trl_q;

    always_comb begin
        trl_d = trl_q;
        if (start) begin
            trl_d.active = 1'b1;
            trl_d.last   = start_last;
            trl_d.beat   = '0;
        end else if (trl_q.active && out_ready) begin
            if (trl_q.beat == BW'(TRL_BEATS - 1)) begin
                trl_d.active = 1'b0;
                trl_d.beat   = '0;
            end else begin
                trl_d.beat = trl_q.beat + BW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trl_q <= '0;
        else        trl_q <= trl_d;
    end

    assign active     = trl_q.active;
    assign data       = {PIX_W{trl_q.last}};
    assign final_beat = (trl_q.beat == BW'(TRL_BEATS - 1));
    assign done       = trl_q.active && out_ready && final_beat;

    // R11
    trl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trl_q.active && !out_ready |=> trl_q.active && $stable(trl_q.beat) && $stable(trl_q.last));

    // R5
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !trl_q.active);
endmodule

// File: rtl/fpk_seg_ctrl.sv
`timescale 1ns/1ps
module fpk_seg_ctrl
    import fpk_pkg::*;
#(
    parameter int MAX_LINES = 1024,
    parameter int LW        = $clog2(MAX_LINES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate,
    input  logic in_valid,
    input  logic pix_acc,
    input  logic pix_eol,
    input  logic trl_done,
    output logic pass_en,
    output logic frame_first,
    output logic trl_start,
    output logic trl_last
);
    typedef struct packed {
        seg_state_e    st;
        logic [LW-1:0] lines;
        logic          open;
    } seg_t;

    seg_t seg_d, seg_q;

    always_comb begin
        seg_d     = seg_q;
        trl_start = 1'b0;
        trl_last  = 1'b0;
        case (seg_q.st)
            SEG_RUN: begin
                if (pix_acc) begin
                    if (pix_eol) begin
                        seg_d.open = 1'b0;
                        if (seg_q.lines == LW'(MAX_LINES - 1)) begin
                            seg_d.lines = LW'(MAX_LINES);
                            seg_d.st    = SEG_FULL;
                        end else begin
                            seg_d.lines = seg_q.lines + LW'(1);
                        end
                    end else begin
                        seg_d.open = 1'b1;
                    end
                end else if (!gate && seg_q.lines != '0 && !seg_q.open) begin
                    trl_start = 1'b1;
                    trl_last  = 1'b1;
                    seg_d.st  = SEG_WAIT;
                end
            end
            SEG_FULL: begin
                if (!gate) begin
                    trl_start = 1'b1;
                    trl_last  = 1'b1;
                    seg_d.st  = SEG_WAIT;
                end else if (in_valid) begin
                    trl_start = 1'b1;
                    trl_last  = 1'b0;
                    seg_d.st  = SEG_WAIT;
                end
            end
            SEG_WAIT: begin
                if (trl_done) begin
                    seg_d.st    = SEG_RUN;
                    seg_d.lines = '0;
                end
            end
            default: seg_d.st = SEG_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seg_q <= '{st: SEG_RUN, lines: '0, open: 1'b0};
        else        seg_q <= seg_d;
    end

    assign pass_en     = (seg_q.st == SEG_RUN);
    assign frame_first = (seg_q.lines == '0) && !seg_q.open;

    // R4
    lines_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg_q.lines <= LW'(MAX_LINES));

    // R4
    full_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg_q.st == SEG_FULL |-> !pix_acc);

    // R12
    gate_in_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg_q.open |-> gate);

    // R9
    empty_no_trailer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trl_start |-> !frame_first);
endmodule

// File: rtl/fpk_gate_packer.sv
`timescale 1ns/1ps
module fpk_gate_packer #(
    parameter int PIX_W     = 8,
    parameter int MAX_LINES = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [PIX_W-1:0] in_data,
    input  logic             in_eol,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [PIX_W-1:0] out_data,
    output logic             out_eol,
    output logic             out_sof,
    output logic             out_eof,
    output logic             out_trl
);
    localparam int TRL_BEATS = 32 / PIX_W;
    localparam int BW        = (TRL_BEATS > 1) ? $clog2(TRL_BEATS) : 1;
    localparam int LW        = $clog2(MAX_LINES + 1);

    logic             pass_en, frame_first, trl_start, trl_last;
    logic             trl_active, trl_final, trl_done, pix_acc;
    logic [PIX_W-1:0] trl_data;

    assign pix_acc = pass_en && gate && in_valid && out_ready;

    fpk_seg_ctrl #(
        .MAX_LINES (MAX_LINES),
        .LW        (LW)
    ) seg_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .gate        (gate),
        .in_valid    (in_valid),
        .pix_acc     (pix_acc),
        .pix_eol     (in_eol),
        .trl_done    (trl_done),
        .pass_en     (pass_en),
        .frame_first (frame_first),
        .trl_start   (trl_start),
        .trl_last    (trl_last)
    );

    fpk_trailer_gen #(
        .PIX_W     (PIX_W),
        .TRL_BEATS (TRL_BEATS),
        .BW        (BW)
    ) trl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (trl_start),
        .start_last (trl_last),
        .out_ready  (out_ready),
        .active     (trl_active),
        .data       (trl_data),
        .final_beat (trl_final),
        .done       (trl_done)
    );

    always_comb begin
        in_ready  = !gate || (pass_en && out_ready);
        out_valid = trl_active || (pass_en && gate && in_valid);
        out_data  = trl_active ? trl_data : in_data;
        out_eol   = trl_active ? trl_final : in_eol;
        out_eof   = trl_active && trl_final;
        out_sof   = !trl_active && frame_first;
        out_trl   = trl_active;
    end

    // R5
    eof_only_trl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_eof |-> out_trl && out_eol);

    // R11
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready && out_trl |=> out_valid && out_trl && $stable(out_data) && $stable(out_eof));

    // R10
    lowgate_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gate && !trl_active |-> !out_valid);
endmodule

// File: tb/fpk_gate_packer_tb_top.sv
`timescale 1ns/1ps
module fpk_gate_packer_tb_top;
    localparam int PIX_W = 8;
    localparam int MAXL  = 4;
    localparam int TRLB  = 32 / PIX_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             gate = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [PIX_W-1:0] in_data = '0;
    logic             in_eol = 1'b0;
    logic             out_valid;
    logic             out_ready = 1'b1;
    logic [PIX_W-1:0] out_data;
    logic             out_eol, out_sof, out_eof, out_trl;

    always #2.5 clk = ~clk;

    fpk_gate_packer #(.PIX_W(PIX_W), .MAX_LINES(MAXL)) dut_i (
        .clk(clk), .rst_n(rst_n), .gate(gate),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_eol(in_eol),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_eol(out_eol), .out_sof(out_sof), .out_eof(out_eof), .out_trl(out_trl)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ready patterns
    int bp_mode = 0;
    int cyc = 0;
    always @(negedge clk) begin
        cyc++;
        case (bp_mode)
            1:       out_ready = (cyc % 3) != 0;
            2:       out_ready = (cyc % 4) < 2;
            default: out_ready = 1'b1;
        endcase
    end

    // capture
    logic [PIX_W-1:0] c_data [0:255];
    bit c_eol [0:255];
    bit c_sof [0:255];
    bit c_eof [0:255];
    bit c_trl [0:255];
    int cap_n = 0;
    bit held_v = 1'b0;
    logic [PIX_W-1:0] held_d;

    initial begin
        forever begin
            @(negedge clk);
            #1.5;
            if (held_v) begin
                // R11 a stalled trailer beat keeps its value
                chk(out_valid && out_trl && out_data == held_d, "R11 trailer hold",
                    int'(out_data), int'(held_d));
                held_v = 1'b0;
            end
            if (out_valid && !out_ready && out_trl) begin
                held_v = 1'b1;
                held_d = out_data;
            end
            if (out_valid && out_ready && cap_n < 256) begin
                c_data[cap_n] = out_data;
                c_eol[cap_n]  = out_eol;
                c_sof[cap_n]  = out_sof;
                c_eof[cap_n]  = out_eof;
                c_trl[cap_n]  = out_trl;
                cap_n++;
            end
        end
    end

    // expected stream
    logic [PIX_W-1:0] e_data [0:255];
    bit e_eol [0:255];
    bit e_sof [0:255];
    bit e_eof [0:255];
    bit e_trl [0:255];
    int e_n;

    function automatic logic [PIX_W-1:0] pxv(input int c, input int l, input int p);
        return PIX_W'(c * 11 + l * 7 + p * 3 + 1);
    endfunction

    task automatic build_exp(input int c, input int nl, input int len);
        int nf;
        e_n = 0;
        nf = (nl + MAXL - 1) / MAXL;
        for (int f = 0; f < nf; f++) begin
            int l_hi;
            l_hi = ((f + 1) * MAXL < nl) ? (f + 1) * MAXL : nl;
            for (int l = f * MAXL; l < l_hi; l++) begin
                for (int p = 0; p < len; p++) begin
                    e_data[e_n] = pxv(c, l, p);
                    e_eol[e_n]  = (p == len - 1);
                    e_sof[e_n]  = (l == f * MAXL) && (p == 0);
                    e_eof[e_n]  = 1'b0;
                    e_trl[e_n]  = 1'b0;
                    e_n++;
                end
            end
            for (int b = 0; b < TRLB; b++) begin
                e_data[e_n] = (f == nf - 1) ? {PIX_W{1'b1}} : '0;
                e_eol[e_n]  = (b == TRLB - 1);
                e_sof[e_n]  = 1'b0;
                e_eof[e_n]  = (b == TRLB - 1);
                e_trl[e_n]  = 1'b1;
                e_n++;
            end
        end
    endtask

    // driver: called at a falling edge, returns at the falling edge after acceptance
    task automatic send_px(input logic [PIX_W-1:0] d, input bit e);
        in_valid = 1'b1;
        in_data  = d;
        in_eol   = e;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_eol   = 1'b0;
    endtask

    task automatic run_case(input int c, input int nl, input int len);
        string dtag;
        build_exp(c, nl, len);
        cap_n = 0;
        // R10 stray pixels while the gate is low
        send_px(8'hA5, 1'b1);
        send_px(8'h5A, 1'b0);
        send_px(8'h3C, 1'b1);
        // R12 the gate moves only between lines
        gate = 1'b1;
        for (int l = 0; l < nl; l++)
            for (int p = 0; p < len; p++)
                send_px(pxv(c, l, p), p == len - 1);
        if (nl == 0) @(negedge clk);
        gate = 1'b0;
        repeat (30) @(negedge clk);
        chk(cap_n == e_n, nl == 0 ? "R9 R10 beat count" : "R4 R10 R11 R12 beat count", cap_n, e_n);
        for (int i = 0; i < e_n && i < cap_n; i++) begin
            if (!e_trl[i])                        dtag = "R2 pixel data";
            else if (e_data[i] == '0)             dtag = "R7 trailer zeros";
            else if (nl % MAXL == 0)              dtag = "R8 trailer ones on full frame";
            else                                  dtag = "R6 trailer ones on partial frame";
            chk(c_data[i] == e_data[i], dtag, int'(c_data[i]), int'(e_data[i]));
            chk(c_eol[i] == e_eol[i], e_trl[i] ? "R5 trailer eol" : "R2 pixel eol",
                int'(c_eol[i]), int'(e_eol[i]));
            chk(c_sof[i] == e_sof[i], "R3 sof", int'(c_sof[i]), int'(e_sof[i]));
            chk(c_eof[i] == e_eof[i], "R5 eof", int'(c_eof[i]), int'(e_eof[i]));
            chk(c_trl[i] == e_trl[i], "R5 trl flag", int'(c_trl[i]), int'(e_trl[i]));
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1
        chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
        @(negedge clk);
        begin
            int c;
            c = 0;
            for (int bp = 0; bp < 3; bp++) begin
                bp_mode = bp;
                for (int len = 1; len <= 3; len++) begin
                    for (int nl = 0; nl <= 2 * MAXL + 1; nl++) begin
                        run_case(c, nl, len);
                        c++;
                    end
                end
            end
        end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule